// File: doc/BRIEF.md
# Output Phase Resynchronization Timer

This block sits beside a fractional-N modulator and decides when that modulator's accumulators are forced back to a known phase. Two nested counters advance on a reference-rate clock enable. Together they produce an internal sync strobe whose period is the product of two programmed counts: a 4-bit period multiplier and a 12-bit delay count. The delay count shares a 12-bit configuration field with the fractional modulus, and a select bit on each configuration write chooses which of the two registers the field loads.

When software commits a new frequency, it pulses a commit event. The block then waits for sync strobes and does not act on the first one that follows. It raises a one-cycle realign strobe together with the second. A fresh commit before that point starts the two-pulse count again. A multiplier of zero or a delay of zero turns the whole feature off. A separate flag reports that the delay is not an integer multiple of the modulus, because the realigned phase is then not consistent from one commit to the next.

Top module: `phase_resync_timer`

## Requirements
- R1: With ref_tick held high, the first sync_o pulse appears in the clock cycle after the (N*D)-th rising edge that follows the configuration write edge. Later pulses repeat every N*D ticks. Each pulse is one clock wide unless N*D is 1. Here N is resync_cnt and D is the delay register.
- R2: When resync_cnt is 0 or the delay register is 0, sync_o and realign_o stay low. A commit_evt that arrives while the feature is disabled is discarded, so it does not cause a realign after the feature is enabled again.
- R3: A cfg_wr with cfg_sel_delay=1 loads cfg_field into the delay register, and one with cfg_sel_delay=0 loads it into the modulus register. Each write leaves the other register unchanged and restarts both counters from zero.
- R4: delay_err_o is cleared by every cfg_wr. It is set in the cycle after the D-th tick following the write when D is not a multiple of the modulus, and it stays set until the next cfg_wr. A modulus of 0 or 1 counts as 1.
- R5: realign_o rises in the same cycle as the second sync_o pulse whose terminal tick edge comes strictly after the commit_evt edge. A sync edge that coincides with the commit edge is not counted.
- R6: realign_o is one clock wide and fires once per commit. It never fires without a prior commit.
- R7: A second commit_evt that arrives before the realign restarts the two-pulse count.
- R8: Clock cycles with ref_tick low do not advance the counters.
- R9: After reset, sync_o, realign_o and delay_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference-rate clock enable |
| commit_evt | input | 1 | One-cycle event marking the frequency commit |
| resync_cnt | input | 4 | Period multiplier N; 0 disables the feature |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_sel_delay | input | 1 | 1: field loads the delay register; 0: field loads the modulus register |
| cfg_field | input | 12 | Shared delay/modulus field value |
| sync_o | output | 1 | Periodic internal sync strobe |
| realign_o | output | 1 | Accumulator realignment strobe |
| delay_err_o | output | 1 | Delay is not a multiple of the modulus |

## Verification
Every result arrives one register after the tick edge that causes it. The first sync is due N*D edges after the write edge and the second 2*N*D edges after it. The error flag is due after the D-th edge, and the realign is due at the second sync period boundary strictly after the commit edge. The bench counts edges from the write edge and samples on the falling edge that follows each rising edge, so each observation belongs to a known edge index. It compares the observed edge index of every pulse with these products, computed in the bench, across all N from 1 to 3, D from 1 to 5 and three moduli. Commit positions are spread over the period, including one that coincides with a sync edge.

// File: rtl/resync_pkg.sv
package resync_pkg;
    localparam int unsigned RS_CNT_W   = 4;
    localparam int unsigned RS_FIELD_W = 12;

    typedef enum logic [1:0] {
        ARM_IDLE = 2'd0,
        ARM_TWO  = 2'd1,
        ARM_ONE  = 2'd2
    } arm_state_e;
endpackage

// File: rtl/resync_field_regs.sv
module resync_field_regs #(
    parameter int unsigned FW = resync_pkg::RS_FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_sel_delay,
    input  logic [FW-1:0] cfg_field,
    output logic [FW-1:0] delay_o,
    output logic [FW-1:0] modulus_o
);
    typedef struct packed {
        logic [FW-1:0] delay;
        logic [FW-1:0] modulus;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_wr) begin
            if (cfg_sel_delay) begin
                regs_d.delay = cfg_field;
            end else begin
                regs_d.modulus = cfg_field;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign delay_o   = regs_q.delay;
    assign modulus_o = regs_q.modulus;

    // R3: a delay write leaves the modulus alone, and the reverse
    p_keep_modulus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel_delay) |=> (modulus_o == $past(modulus_o)));
    p_keep_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_sel_delay) |=> (delay_o == $past(delay_o)));
endmodule

// File: rtl/resync_period_gen.sv
module resync_period_gen #(
    parameter int unsigned CW = resync_pkg::RS_CNT_W,
    parameter int unsigned FW = resync_pkg::RS_FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    input  logic [CW-1:0] period_cnt,
    input  logic [FW-1:0] delay,
    input  logic [FW-1:0] modulus,
    output logic          en_o,
    output logic          event_o,
    output logic          sync_o,
    output logic          err_o
);
    typedef struct packed {
        logic [FW-1:0] inner;
        logic [CW-1:0] outer;
        logic [FW-1:0] mph;
        logic          sync;
        logic          err;
    } gen_t;

    gen_t gen_d, gen_q;

    logic          en;
    logic [FW-1:0] delay_last;
    logic [FW-1:0] mod_last;
    logic [CW-1:0] outer_limit;
    logic          inner_last;
    logic          outer_last;
    logic          mph_last;

    always_comb begin
        en          = (period_cnt != '0) && (delay != '0);
        delay_last  = delay - 1'b1;
        mod_last    = (modulus > FW'(1)) ? (modulus - 1'b1) : '0;
        outer_limit = period_cnt - 1'b1;
        inner_last  = (gen_q.inner >= delay_last);
        outer_last  = (gen_q.outer >= outer_limit);
        mph_last    = (gen_q.mph >= mod_last);

        gen_d      = gen_q;
        gen_d.sync = 1'b0;
        if (restart || !en) begin
            gen_d.inner = '0;
            gen_d.outer = '0;
            gen_d.mph   = '0;
            gen_d.err   = 1'b0;
        end else if (tick) begin
            gen_d.mph = mph_last ? '0 : (gen_q.mph + 1'b1);
            if (inner_last) begin
                gen_d.inner = '0;
                if (!mph_last) begin
                    gen_d.err = 1'b1;
                end
                if (outer_last) begin
                    gen_d.outer = '0;
                    gen_d.sync  = 1'b1;
                end else begin
                    gen_d.outer = gen_q.outer + 1'b1;
                end
            end else begin
                gen_d.inner = gen_q.inner + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign en_o    = en;
    assign event_o = gen_d.sync;
    assign sync_o  = gen_q.sync;
    assign err_o   = gen_q.err;

    // R1: inner counter stays below the programmed delay
    p_inner_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (delay != '0) |-> (gen_q.inner < delay));
    // R1: pulses are isolated unless the period is a single tick
    p_sync_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && !(period_cnt == CW'(1) && delay == FW'(1))) |=> !sync_o);
    // R2: no sync while disabled
    p_quiet_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sync_o);
    // R4: error flag holds until a configuration write
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !restart && en) |=> err_o);
endmodule

// File: rtl/resync_arm.sv
module resync_arm
    import resync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic commit,
    input  logic sync_event,
    output logic realign_o
);
    typedef struct packed {
        arm_state_e pend;
        logic       realign;
    } arm_t;

    arm_t arm_d, arm_q;

    always_comb begin
        arm_d         = arm_q;
        arm_d.realign = 1'b0;
        if (!en) begin
            arm_d.pend = ARM_IDLE;
        end else if (commit) begin
            arm_d.pend = ARM_TWO;
        end else if (sync_event) begin
            case (arm_q.pend)
                ARM_TWO: arm_d.pend = ARM_ONE;
                ARM_ONE: begin
                    arm_d.pend    = ARM_IDLE;
                    arm_d.realign = 1'b1;
                end
                default: arm_d.pend = ARM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= '{pend: ARM_IDLE, realign: 1'b0};
        end else begin
            arm_q <= arm_d;
        end
    end

    assign realign_o = arm_q.realign;

    // R6: one-cycle strobe
    p_realign_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        realign_o |=> !realign_o);
    // R6: nothing fires while nothing is pending
    p_no_realign_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q.pend == ARM_IDLE) |=> !realign_o);
endmodule

// File: rtl/phase_resync_timer.sv
module phase_resync_timer #(
    parameter int unsigned CW = resync_pkg::RS_CNT_W,
    parameter int unsigned FW = resync_pkg::RS_FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_tick,
    input  logic          commit_evt,
    input  logic [CW-1:0] resync_cnt,
    input  logic          cfg_wr,
    input  logic          cfg_sel_delay,
    input  logic [FW-1:0] cfg_field,
    output logic          sync_o,
    output logic          realign_o,
    output logic          delay_err_o
);
    logic [FW-1:0] delay_w;
    logic [FW-1:0] modulus_w;
    logic          en_w;
    logic          event_w;

    resync_field_regs #(.FW(FW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_sel_delay(cfg_sel_delay),
        .cfg_field    (cfg_field),
        .delay_o      (delay_w),
        .modulus_o    (modulus_w)
    );

    resync_period_gen #(.CW(CW), .FW(FW)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ref_tick),
        .restart   (cfg_wr),
        .period_cnt(resync_cnt),
        .delay     (delay_w),
        .modulus   (modulus_w),
        .en_o      (en_w),
        .event_o   (event_w),
        .sync_o    (sync_o),
        .err_o     (delay_err_o)
    );

    resync_arm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_w),
        .commit    (commit_evt),
        .sync_event(event_w),
        .realign_o (realign_o)
    );

    // R5: realignment always coincides with a sync pulse
    p_realign_on_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        realign_o |-> sync_o);
endmodule

// File: tb/phase_resync_timer_test.sv
module phase_resync_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic        commit_evt = 1'b0;
    logic [3:0]  resync_cnt = 4'd0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel_delay = 1'b0;
    logic [11:0] cfg_field = 12'd0;
    logic        sync_o, realign_o, delay_err_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    phase_resync_timer uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .commit_evt(commit_evt),
        .resync_cnt(resync_cnt), .cfg_wr(cfg_wr), .cfg_sel_delay(cfg_sel_delay),
        .cfg_field(cfg_field), .sync_o(sync_o), .realign_o(realign_o),
        .delay_err_o(delay_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ends on the falling edge after the write edge (edge index 0)
    task automatic wr(input logic sel, input int v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel_delay = sel; cfg_field = 12'(v);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic run_combo(input int n, input int d, input int m, input int k0);
        int p, first, second, rl, nrl, nsync, err_pre, err_at, exp_rl, meff;
        p = n * d; first = -1; second = -1; rl = -1; nrl = 0; nsync = 0;
        err_pre = 0; err_at = 0;
        meff = (m <= 1) ? 1 : m;
        resync_cnt = 4'(n);
        wr(1'b1, d);
        wr(1'b0, m);
        for (int k = 0; k <= 3*p + 1; k++) begin
            if (k > 0 && sync_o) begin
                nsync++;
                if (first < 0) first = k;
                else if (second < 0) second = k;
            end
            if (realign_o) begin
                nrl++;
                if (rl < 0) rl = k;
            end
            if (k == d - 1) err_pre = delay_err_o;
            if (k == d) err_at = delay_err_o;
            commit_evt = (k == k0 - 1);
            @(negedge clk);
        end
        commit_evt = 1'b0;
        exp_rl = p * ((k0 / p) + 2);
        chk("R1", "first sync edge", first, p);
        chk("R1", "second sync edge", second, 2*p);
        chk("R1", "sync count", nsync, (3*p + 1) / p);
        chk("R3", "period after modulus write", second - first, p);
        chk("R4", "err before D-th tick", err_pre, 0);
        chk("R4", "err after D-th tick", err_at, (d % meff) != 0 ? 1 : 0);
        chk("R4", "err sticky", delay_err_o, (d % meff) != 0 ? 1 : 0);
        chk("R5", "realign edge", rl, exp_rl);
        chk("R6", "realign count", nrl, 1);
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        chk("R9", "sync at reset", sync_o, 0);
        chk("R9", "realign at reset", realign_o, 0);
        chk("R9", "err at reset", delay_err_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: period multiplier, delay, modulus
        for (int n = 1; n <= 3; n++)
            for (int d = 1; d <= 5; d++)
                for (int mi = 0; mi < 3; mi++) begin
                    int m, k0;
                    m = (mi == 0) ? 0 : mi + 1;
                    k0 = ((n*7 + d*3 + mi) % (n*d)) + 1;
                    run_combo(n, d, m, k0);
                end

        // R2: disabled by resync_cnt = 0, commit dropped
        resync_cnt = 4'd0;
        wr(1'b1, 5);
        wr(1'b0, 1);
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            cnt += int'(sync_o) + int'(realign_o);
            commit_evt = (k == 3);
            @(negedge clk);
        end
        commit_evt = 1'b0;
        chk("R2", "pulses with N=0", cnt, 0);
        resync_cnt = 4'd2;
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            cnt += int'(realign_o);
            @(negedge clk);
        end
        chk("R2", "dropped commit realigns", cnt, 0);

        // R2: disabled by delay = 0
        wr(1'b1, 0);
        cnt = 0;
        for (int k = 0; k < 30; k++) begin
            cnt += int'(sync_o);
            @(negedge clk);
        end
        chk("R2", "pulses with D=0", cnt, 0);

        // R7: second commit restarts the count (N=2, D=3, P=6)
        resync_cnt = 4'd2;
        wr(1'b1, 3);
        wr(1'b0, 3);
        cnt = -1;
        for (int k = 0; k < 22; k++) begin
            if (realign_o && cnt < 0) cnt = k;
            commit_evt = (k == 0) || (k == 6);
            @(negedge clk);
        end
        commit_evt = 1'b0;
        chk("R7", "realign after recommit", cnt, 18);

        // R8: ticks on odd edges only (N=2, D=2 -> 4th tick at edge 7)
        resync_cnt = 4'd2;
        wr(1'b1, 2);
        wr(1'b0, 1);
        cnt = -1;
        for (int k = 0; k < 12; k++) begin
            if (sync_o && k > 0 && cnt < 0) cnt = k;
            ref_tick = (k % 2 == 0);
            @(negedge clk);
        end
        ref_tick = 1'b1;
        chk("R8", "first sync with gated ticks", cnt, 7);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule